// File: doc/BRIEF.md
# Over-current circuit breaker with regulation window

This block is the digital half of a hot-swap over-current protector. Two comparators outside the block report whether the sense-resistor voltage is above the fixed 50 mV level (`oc_i`) and whether it is above the selected quick-trip level (`oc_qt_i`). The block chooses the quick-trip level by driving a code to that comparator, and it answers with a one-cycle trip pulse, a held fault flag that keeps the pass device off, and a request to pull the gate down while current is being regulated.

An ordinary over-current must last for a programmed filter time before it trips. A quick-trip hit trips at once and overrides both the filter and the regulation window. When regulation is enabled, an ordinary over-current does not use the filter. It asks for gate pull-down and runs a millisecond window instead, which restarts whenever the current falls back below 50 mV. After a trip the block either stays off until software clears it, or waits out a cool-down time and re-arms on its own.

All timers run from one clock, using a microsecond prescale (`CLKS_PER_US`) and a millisecond prescale (`US_PER_MS`). A period of P units therefore lasts exactly P times the prescale in clock cycles.

Top module: `oc_breaker`

## Requirements
- R1: With regulation disabled and the block armed, `oc_i` held high trips `trip_o` exactly F·CLKS_PER_US clock edges after the first edge that samples it high (trip visible after that edge). F is 5, 50, 150 or 400 µs for `filt_sel_i` = 00, 01, 10 or 11.
- R2: If `oc_i` falls before the filter time runs out, the count is discarded, and a new episode needs the full filter time again.
- R3: When armed, with `qt_code_o` nonzero, `oc_qt_i` sampled high at an edge makes `trip_o` high right after that edge. This bypasses both the filter and the regulation window, and also holds when a filter expiry falls on the same edge; only one pulse results.
- R4: `qt_code_o` copies `qt_sel_i` one cycle later (00 off, 01 60 mV, 10 100 mV, 11 200 mV). A new code takes effect at the edge after it appears on `qt_code_o`. With code 00, `oc_qt_i` has no effect.
- R5: With `reg_en_i` high and the block armed, `oc_i` high without a quick-trip hit drives `reg_down_o` high in the same cycle. A continuous episode trips after R·CLKS_PER_US·US_PER_MS edges, where R is 5, 80, 320 or 320 ms for `reg_sel_i` = 00, 01, 10 or 11; the filter time plays no part.
- R6: When `oc_i` falls during regulation, `reg_down_o` drops and the regulation count restarts from zero.
- R7: `trip_o` lasts one cycle, and `fault_o` rises with it and stays high. While `fault_o` is high there are no new trips and `reg_down_o` stays low.
- R8: If `retry_mode_i` is 0 at the trip, `fault_o` stays high until `fault_clr_i` is sampled high. It falls right after that edge, and over-current inputs in that same cycle are ignored.
- R9: If `retry_mode_i` is 1 at the trip, `fault_o` stays high for C·CLKS_PER_US·US_PER_MS + 1 cycles and then re-arms. C is 2500 ms for `cyc_sel_i` = 0 and 5000 ms for 1. `fault_clr_i` has no effect in this mode.
- R10: Reset drives `trip_o`, `fault_o` and `reg_down_o` low and sets `qt_code_o` to 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| oc_i | input | 1 | Sense above the 50 mV level |
| oc_qt_i | input | 1 | Sense above the selected quick-trip level |
| filt_sel_i | input | 2 | Filter time select |
| qt_sel_i | input | 2 | Quick-trip level select |
| reg_en_i | input | 1 | Enable current regulation window |
| reg_sel_i | input | 2 | Regulation window select |
| retry_mode_i | input | 1 | 0 latched off, 1 timed retry |
| cyc_sel_i | input | 1 | Cool-down time select |
| fault_clr_i | input | 1 | Clears a latched fault |
| trip_o | output | 1 | One-cycle trip pulse |
| fault_o | output | 1 | Fault held, pass device off |
| reg_down_o | output | 1 | Request to lower the gate drive |
| qt_code_o | output | 2 | Level code for the quick-trip comparator |

## Verification
Two pairs of events can collide in a single cycle. First, a quick-trip hit can land on the same edge at which the filter timer expires. The bench holds `oc_i` for exactly the filter length minus one edge, raises `oc_qt_i` just before the expiring edge, and expects one trip pulse at that edge with no second pulse after it. Second, a latched fault can be cleared in the same cycle that a quick-trip hit is present. The bench expects the clear to win, so `fault_o` falls with no trip, and the still-present hit trips on the following edge.

// File: rtl/oc_breaker_pkg.sv
package oc_breaker_pkg;

  localparam int FILT_W = 9;   // µs, up to 400
  localparam int REG_W  = 9;   // ms, up to 320
  localparam int CYC_W  = 13;  // ms, up to 5000

  localparam logic [1:0] QT_OFF     = 2'b00;
  localparam logic [1:0] QT_DEFAULT = 2'b10;

  typedef enum logic [1:0] {
    ST_ARMED   = 2'd0,
    ST_LATCHED = 2'd1,
    ST_COOL    = 2'd2
  } brk_state_e;

  function automatic logic [FILT_W-1:0] filt_us(input logic [1:0] sel);
    case (sel)
      2'b00:   filt_us = FILT_W'(5);
      2'b01:   filt_us = FILT_W'(50);
      2'b10:   filt_us = FILT_W'(150);
      default: filt_us = FILT_W'(400);
    endcase
  endfunction

  function automatic logic [REG_W-1:0] reg_ms(input logic [1:0] sel);
    case (sel)
      2'b00:   reg_ms = REG_W'(5);
      2'b01:   reg_ms = REG_W'(80);
      default: reg_ms = REG_W'(320);
    endcase
  endfunction

  function automatic logic [CYC_W-1:0] cyc_ms(input logic sel);
    cyc_ms = sel ? CYC_W'(5000) : CYC_W'(2500);
  endfunction

endpackage

// File: rtl/ocb_interval_timer.sv
module ocb_interval_timer #(
  parameter int CLKS_PER_UNIT = 250,
  parameter int UNIT_W        = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [UNIT_W-1:0] limit_i,
  output logic              done_o
);

  localparam int PRE_W = (CLKS_PER_UNIT > 1) ? $clog2(CLKS_PER_UNIT) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLKS_PER_UNIT - 1);

  logic [PRE_W-1:0]  pre_q;
  logic [UNIT_W-1:0] unit_q;
  logic              at_limit;

  assign at_limit = (unit_q == limit_i);
  assign done_o   = run_i && at_limit;

  // prescaler restarts with each run so the period is exact
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      unit_q <= '0;
    end else if (!run_i) begin
      pre_q  <= '0;
      unit_q <= '0;
    end else if (!at_limit) begin
      if (pre_q == PRE_LAST) begin
        pre_q  <= '0;
        unit_q <= unit_q + 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  AST_UNIT_MONOTONIC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i)) |-> (unit_q >= $past(unit_q))); // R2

  AST_IDLE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (unit_q == '0)); // R2

endmodule

// File: rtl/ocb_cfg_decode.sv
module ocb_cfg_decode
  import oc_breaker_pkg::*;
(
  input  logic [1:0]        filt_sel_i,
  input  logic [1:0]        reg_sel_i,
  input  logic              cyc_sel_i,
  input  logic [1:0]        qt_code_i,
  output logic [FILT_W-1:0] filt_lim_o,
  output logic [REG_W-1:0]  reg_lim_o,
  output logic [CYC_W-1:0]  cyc_lim_o,
  output logic              qt_armed_o
);

  assign filt_lim_o = filt_us(filt_sel_i);
  assign reg_lim_o  = reg_ms(reg_sel_i);
  assign cyc_lim_o  = cyc_ms(cyc_sel_i);
  assign qt_armed_o = (qt_code_i != QT_OFF);

endmodule

// File: rtl/oc_breaker.sv
module oc_breaker
  import oc_breaker_pkg::*;
#(
  parameter int CLKS_PER_US = 250,
  parameter int US_PER_MS   = 1000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       oc_i,
  input  logic       oc_qt_i,
  input  logic [1:0] filt_sel_i,
  input  logic [1:0] qt_sel_i,
  input  logic       reg_en_i,
  input  logic [1:0] reg_sel_i,
  input  logic       retry_mode_i,
  input  logic       cyc_sel_i,
  input  logic       fault_clr_i,
  output logic       trip_o,
  output logic       fault_o,
  output logic       reg_down_o,
  output logic [1:0] qt_code_o
);

  localparam int CLKS_PER_MS = CLKS_PER_US * US_PER_MS;

  brk_state_e        state_q, state_d;
  logic [1:0]        qt_code_q;
  logic              trip_q;
  logic [FILT_W-1:0] filt_lim;
  logic [REG_W-1:0]  reg_lim;
  logic [CYC_W-1:0]  cyc_lim;
  logic              qt_armed;
  logic              armed, qt_hit, ov_hit;
  logic              filt_run, reg_run, cool_run;
  logic              filt_done, reg_done, cool_done;
  logic              trip_now;

  ocb_cfg_decode u_decode (
    .filt_sel_i (filt_sel_i),
    .reg_sel_i  (reg_sel_i),
    .cyc_sel_i  (cyc_sel_i),
    .qt_code_i  (qt_code_q),
    .filt_lim_o (filt_lim),
    .reg_lim_o  (reg_lim),
    .cyc_lim_o  (cyc_lim),
    .qt_armed_o (qt_armed)
  );

  assign armed    = (state_q == ST_ARMED);
  assign qt_hit   = armed && oc_qt_i && qt_armed;
  assign ov_hit   = armed && oc_i && !qt_hit;
  assign filt_run = ov_hit && !reg_en_i;
  assign reg_run  = ov_hit && reg_en_i;
  assign cool_run = (state_q == ST_COOL);

  ocb_interval_timer #(.CLKS_PER_UNIT(CLKS_PER_US), .UNIT_W(FILT_W)) u_filt_tmr (
    .clk_i, .rst_ni, .run_i(filt_run), .limit_i(filt_lim), .done_o(filt_done)
  );

  ocb_interval_timer #(.CLKS_PER_UNIT(CLKS_PER_MS), .UNIT_W(REG_W)) u_reg_tmr (
    .clk_i, .rst_ni, .run_i(reg_run), .limit_i(reg_lim), .done_o(reg_done)
  );

  ocb_interval_timer #(.CLKS_PER_UNIT(CLKS_PER_MS), .UNIT_W(CYC_W)) u_cool_tmr (
    .clk_i, .rst_ni, .run_i(cool_run), .limit_i(cyc_lim), .done_o(cool_done)
  );

  // quick trip bypasses both windows
  assign trip_now = qt_hit || filt_done || reg_done;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_ARMED:   if (trip_now) state_d = retry_mode_i ? ST_COOL : ST_LATCHED;
      ST_LATCHED: if (fault_clr_i) state_d = ST_ARMED;
      ST_COOL:    if (cool_done) state_d = ST_ARMED;
      default:    state_d = ST_ARMED;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_ARMED;
      trip_q    <= 1'b0;
      qt_code_q <= QT_DEFAULT;
    end else begin
      state_q   <= state_d;
      trip_q    <= armed && trip_now;
      qt_code_q <= qt_sel_i;
    end
  end

  assign trip_o     = trip_q;
  assign fault_o    = !armed;
  assign reg_down_o = reg_run;
  assign qt_code_o  = qt_code_q;

  AST_TRIP_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trip_o |=> !trip_o); // R7

  AST_TRIP_SETS_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trip_o |-> fault_o); // R7

  AST_NO_REG_IN_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> !reg_down_o); // R7

  AST_QUICK_NEXT_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fault_o && oc_qt_i && qt_code_o != QT_OFF) |=> trip_o); // R3

  AST_LATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LATCHED && !fault_clr_i) |=> fault_o); // R8

  AST_COOL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_COOL && !cool_done) |=> fault_o); // R9

  AST_NO_TRIP_IN_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o && !trip_o) |=> !trip_o); // R7

endmodule

// File: tb/oc_breaker_test.sv
module oc_breaker_test;

  localparam int CPU = 2;
  localparam int UPM = 4;
  localparam int CPM = CPU * UPM;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       oc = 1'b0, oc_qt = 1'b0;
  logic [1:0] filt_sel = 2'b01, qt_sel = 2'b10, reg_sel = 2'b00;
  logic       reg_en = 1'b0, retry = 1'b0, cyc_sel = 1'b0, clr = 1'b0;
  logic       trip, fault, reg_down;
  logic [1:0] qt_code;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  oc_breaker #(.CLKS_PER_US(CPU), .US_PER_MS(UPM)) uut (
    .clk_i(clk), .rst_ni(rst_n), .oc_i(oc), .oc_qt_i(oc_qt),
    .filt_sel_i(filt_sel), .qt_sel_i(qt_sel), .reg_en_i(reg_en),
    .reg_sel_i(reg_sel), .retry_mode_i(retry), .cyc_sel_i(cyc_sel),
    .fault_clr_i(clr), .trip_o(trip), .fault_o(fault),
    .reg_down_o(reg_down), .qt_code_o(qt_code)
  );

  function automatic int filt_cyc(input logic [1:0] s);
    case (s) 2'b00: return 5*CPU; 2'b01: return 50*CPU; 2'b10: return 150*CPU; default: return 400*CPU; endcase
  endfunction

  function automatic int reg_cyc(input logic [1:0] s);
    case (s) 2'b00: return 5*CPM; 2'b01: return 80*CPM; default: return 320*CPM; endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    oc = 0; oc_qt = 0; filt_sel = 2'b01; qt_sel = 2'b10; reg_en = 0;
    reg_sel = 0; retry = 0; cyc_sel = 0; clr = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // counts negedges from now until trip_o is seen
  task automatic wait_trip(input int start, input int cap, output int n);
    n = start;
    do begin
      @(negedge clk);
      n++;
    end while (!trip && n < cap);
    if (!trip) n = -1;
  endtask

  task automatic t_reset();
    do_reset();
    check(trip == 0, "R10 trip", int'(trip), 0);
    check(fault == 0, "R10 fault", int'(fault), 0);
    check(reg_down == 0, "R10 reg_down", int'(reg_down), 0);
    check(qt_code == 2'b10, "R10 qt_code", int'(qt_code), 2);
  endtask

  task automatic t_filter(input logic [1:0] s);
    int n;
    do_reset();
    filt_sel = s;
    oc = 1'b1;
    wait_trip(0, 2000, n);
    check(n == filt_cyc(s) + 1, "R1 filter delay", n, filt_cyc(s) + 1);
    check(fault == 1, "R7 fault with trip", int'(fault), 1);
    @(negedge clk);
    check(trip == 0, "R7 single pulse", int'(trip), 0);
    check(fault == 1, "R7 fault held", int'(fault), 1);
  endtask

  task automatic t_filter_restart();
    int n;
    int seen = 0;
    do_reset();
    filt_sel = 2'b01;
    oc = 1'b1;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (trip) seen++;
    end
    oc = 1'b0;
    @(negedge clk);
    check(seen == 0 && trip == 0, "R2 no early trip", seen, 0);
    oc = 1'b1;
    wait_trip(0, 2000, n);
    check(n == filt_cyc(2'b01) + 1, "R2 full restart", n, filt_cyc(2'b01) + 1);
  endtask

  task automatic t_quick(input bit with_reg);
    int n;
    do_reset();
    filt_sel = 2'b11;
    reg_en = with_reg;
    reg_sel = 2'b10;
    oc = 1'b1;
    repeat (5) @(negedge clk);
    oc_qt = 1'b1;
    wait_trip(0, 50, n);
    check(n == 1, "R3 quick trip latency", n, 1);
    check(reg_down == 0, "R7 no reg in fault", int'(reg_down), 0);
  endtask

  task automatic t_qt_code();
    int seen = 0;
    do_reset();
    qt_sel = 2'b00;
    repeat (2) @(negedge clk);
    check(qt_code == 2'b00, "R4 code follows", int'(qt_code), 0);
    oc_qt = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (trip || fault) seen++;
    end
    check(seen == 0, "R4 flag ignored when off", seen, 0);
    qt_sel = 2'b11;
    @(negedge clk);
    check(qt_code == 2'b11, "R4 code one cycle later", int'(qt_code), 3);
    check(trip == 0, "R4 not yet active", int'(trip), 0);
    @(negedge clk);
    check(trip == 1, "R4 active after shown", int'(trip), 1);
  endtask

  task automatic t_reg(input logic [1:0] s);
    int n;
    do_reset();
    filt_sel = 2'b00;
    reg_en = 1'b1;
    reg_sel = s;
    oc = 1'b1;
    @(negedge clk);
    check(reg_down == 1, "R5 reg_down asserted", int'(reg_down), 1);
    wait_trip(1, 5000, n);
    check(n == reg_cyc(s) + 1, "R5 regulation window", n, reg_cyc(s) + 1);
    check(reg_down == 0, "R7 reg released on trip", int'(reg_down), 0);
  endtask

  task automatic t_reg_recover();
    int n;
    int seen = 0;
    do_reset();
    reg_en = 1'b1;
    reg_sel = 2'b00;
    oc = 1'b1;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (trip) seen++;
    end
    oc = 1'b0;
    @(negedge clk);
    check(reg_down == 0, "R6 reg_down drops", int'(reg_down), 0);
    check(seen == 0 && fault == 0, "R6 no trip", seen, 0);
    oc = 1'b1;
    wait_trip(0, 5000, n);
    check(n == reg_cyc(2'b00) + 1, "R6 timer restarted", n, reg_cyc(2'b00) + 1);
  endtask

  task automatic t_latched();
    int n;
    int seen = 0;
    do_reset();
    retry = 1'b0;
    oc_qt = 1'b1;
    wait_trip(0, 50, n);
    oc_qt = 1'b0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (!fault || trip) seen++;
    end
    check(seen == 0, "R8 fault held", seen, 0);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    check(fault == 0, "R8 cleared", int'(fault), 0);
  endtask

  task automatic t_duty(input logic c);
    int n;
    int exp;
    do_reset();
    retry = 1'b1;
    cyc_sel = c;
    exp = (c ? 5000 : 2500) * CPM + 1;
    oc_qt = 1'b1;
    wait_trip(0, 50, n);
    oc_qt = 1'b0;
    n = 0;
    do begin
      @(negedge clk);
      n++;
      clr = (n == 10);
    end while (fault && n < exp + 100);
    clr = 1'b0;
    check(n == exp, "R9 cool-down length", n, exp);
  endtask

  task automatic t_same_edge_filter_quick();
    int seen = 0;
    do_reset();
    filt_sel = 2'b00;
    oc = 1'b1;
    for (int i = 0; i < filt_cyc(2'b00); i++) begin
      @(negedge clk);
      if (trip) seen++;
    end
    check(seen == 0, "R1 no trip before expiry", seen, 0);
    oc_qt = 1'b1;
    @(negedge clk);
    check(trip == 1, "R3 coincident trip", int'(trip), 1);
    @(negedge clk);
    check(trip == 0, "R7 one pulse on collision", int'(trip), 0);
  endtask

  task automatic t_clear_with_quick();
    int n;
    do_reset();
    oc_qt = 1'b1;
    wait_trip(0, 50, n);
    repeat (5) @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    check(fault == 0 && trip == 0, "R8 clear wins", int'(fault) + int'(trip), 0);
    @(negedge clk);
    check(trip == 1, "R3 trip after clear", int'(trip), 1);
  endtask

  initial begin
    #(190000 * 4);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    for (int s = 0; s < 4; s++) t_filter(2'(s));
    t_filter_restart();
    t_quick(1'b0);
    t_quick(1'b1);
    t_qt_code();
    for (int s = 0; s < 3; s++) t_reg(2'(s));
    t_reg_recover();
    t_latched();
    t_duty(1'b0);
    t_duty(1'b1);
    t_same_edge_filter_quick();
    t_clear_with_quick();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule